// File: doc/BRIEF.md
# Power Management Mode Controller

This block is the mode-control state machine of a system basis chip that supervises a microcontroller. It holds the current operating mode: Init, Normal, Stop, Sleep, Restart or Fail-Safe. From that mode it drives the main regulator enable, the microcontroller reset and the watchdog-run enable. Software asks for a mode change through a single-cycle register-write strobe that carries a 3-bit code. The read-back port always shows the mode the controller is actually in.

Status flags come in from blocks outside this one: wake, watchdog failure, main-supply undervoltage, severe overtemperature, main-supply short and the test strap. These flags override software requests in a fixed priority order. Thermal or short faults latch the controller in Fail-Safe. Watchdog and supply failures send it through Restart, which holds the microcontroller in reset for a fixed number of clocks and then returns to Normal on its own. A development strap, sampled low while the controller is in Init, stops the watchdog and leaves every mode reachable.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode reads Init (000), the regulator is enabled, the microcontroller reset is released and the watchdog runs.
- R2: Mode codes are Init=000, Normal=001, Stop=010, Sleep=011, Restart=100, Fail-Safe=101. A write of one of these codes while in Init, Normal or Stop takes effect on the next clock. Writing 000 acts as a soft reset into Init. Codes 110 and 111 are ignored.
- R3: Writes are ignored while the mode is Sleep, Restart or Fail-Safe.
- R4: The regulator enable is low only in Sleep and Fail-Safe. The microcontroller reset is high in Restart, Sleep and Fail-Safe and low otherwise.
- R5: Overtemperature or supply short moves any mode to Fail-Safe on the next clock. This has priority over every other input.
- R6: Fail-Safe is held until wake is high while overtemperature is low. Restart then follows on the next clock.
- R7: A watchdog failure or an undervoltage in Init, Normal, Stop or Restart moves to (or stays in) Restart on the next clock. Both are ignored in Sleep.
- R8: Wake in Sleep moves to Restart on the next clock. Wake has no effect in Init, Normal or Stop.
- R9: Restart lasts exactly RESTART_CYC clocks without a failure and then reads Normal, so the requested code is cleared by the pass. A failure during Restart starts the count again.
- R10: If the test strap is low in a cycle where the mode is Init, development mode latches until the next reset. In development mode the watchdog-run output is low and watchdog failures are ignored, while undervoltage still forces Restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Mode-request write strobe |
| wr_code_i | input | 3 | Requested mode code |
| wake_i | input | 1 | Wake event flag |
| wdog_fail_i | input | 1 | Watchdog failure flag |
| uv_i | input | 1 | Main-supply undervoltage flag |
| tsd_i | input | 1 | Severe overtemperature flag |
| short_i | input | 1 | Main-supply short-to-ground flag |
| test_n_i | input | 1 | Development strap, active low |
| mode_o | output | 3 | Current mode code |
| vreg_en_o | output | 1 | Main regulator enable |
| mcu_rst_o | output | 1 | Microcontroller reset |
| wdog_run_o | output | 1 | Watchdog run enable |

## Verification
The assertions check these on every cycle: thermal and short faults reach Fail-Safe one clock later, Fail-Safe holds without a wake, undervoltage forces a held Restart, illegal codes leave the mode unchanged, and Sleep never runs the watchdog or powers the regulator. Some behaviours can only be shown by the bench's scenarios: the exact length of Restart, the counter starting again after a mid-delay failure, the latching of the development strap across later mode changes, and the rejection of writes in the controller-owned modes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_INIT     = 3'b000,
        PM_NORMAL   = 3'b001,
        PM_STOP     = 3'b010,
        PM_SLEEP    = 3'b011,
        PM_RESTART  = 3'b100,
        PM_FAILSAFE = 3'b101
    } pmc_mode_e;

    typedef struct packed {
        logic fs_trig;   // overtemperature or supply short
        logic fail;      // watchdog (when not masked) or undervoltage
        logic wake;
        logic overtemp;
    } pmc_evt_t;

    function automatic logic code_is_legal(input logic [2:0] code);
        return code <= 3'b101;
    endfunction

    function automatic logic mode_has_supply(input pmc_mode_e m);
        return !(m == PM_SLEEP || m == PM_FAILSAFE);
    endfunction

    function automatic logic mode_holds_reset(input pmc_mode_e m);
        return (m == PM_RESTART) || (m == PM_SLEEP) || (m == PM_FAILSAFE);
    endfunction

    function automatic logic mode_runs_wdog(input pmc_mode_e m);
        return (m == PM_INIT) || (m == PM_NORMAL) || (m == PM_STOP);
    endfunction

endpackage

// File: rtl/pmc_dev_strap.sv
module pmc_dev_strap (
    input  logic clk,
    input  logic rst,
    input  logic in_init,
    input  logic test_n,
    output logic dev_o
);
    always_ff @(posedge clk) begin
        if (rst)
            dev_o <= 1'b0;
        else if (in_init && !test_n)
            dev_o <= 1'b1;
    end
endmodule

// File: rtl/pmc_restart_timer.sv
module pmc_restart_timer #(
    parameter int unsigned RESTART_CYC = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic in_restart,
    input  logic fail,
    output logic done_o
);
    localparam int unsigned CW = (RESTART_CYC > 2) ? $clog2(RESTART_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(RESTART_CYC - 1);

    logic [CW-1:0] cnt;

    assign done_o = in_restart && !fail && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !in_restart || fail || done_o)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pmc_next_mode.sv
module pmc_next_mode
    import pmc_pkg::*;
(
    input  pmc_mode_e  cur,
    input  pmc_evt_t   evt,
    input  logic       wr_en,
    input  logic [2:0] wr_code,
    input  logic       timer_done,
    output pmc_mode_e  nxt
);
    always_comb begin
        nxt = cur;
        if (evt.fs_trig) begin
            nxt = PM_FAILSAFE;
        end else if (cur == PM_FAILSAFE) begin
            if (evt.wake && !evt.overtemp)
                nxt = PM_RESTART;
        end else if (cur == PM_SLEEP) begin
            if (evt.wake)
                nxt = PM_RESTART;
        end else if (evt.fail) begin
            nxt = PM_RESTART;
        end else if (cur == PM_RESTART) begin
            if (timer_done)
                nxt = PM_NORMAL;
        end else if (wr_en && code_is_legal(wr_code)) begin
            nxt = pmc_mode_e'(wr_code);
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned RESTART_CYC = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en_i,
    input  logic [2:0] wr_code_i,
    input  logic       wake_i,
    input  logic       wdog_fail_i,
    input  logic       uv_i,
    input  logic       tsd_i,
    input  logic       short_i,
    input  logic       test_n_i,
    output logic [2:0] mode_o,
    output logic       vreg_en_o,
    output logic       mcu_rst_o,
    output logic       wdog_run_o
);
    pmc_mode_e mode_q;
    pmc_mode_e mode_d;
    pmc_evt_t  evt;
    logic      dev_mode;
    logic      timer_done;

    pmc_dev_strap u_strap (
        .clk     (clk),
        .rst     (rst),
        .in_init (mode_q == PM_INIT),
        .test_n  (test_n_i),
        .dev_o   (dev_mode)
    );

    always_comb begin
        evt.fs_trig  = tsd_i | short_i;
        evt.fail     = (wdog_fail_i & ~dev_mode) | uv_i;
        evt.wake     = wake_i;
        evt.overtemp = tsd_i;
    end

    pmc_restart_timer #(.RESTART_CYC(RESTART_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .in_restart (mode_q == PM_RESTART),
        .fail       (evt.fail),
        .done_o     (timer_done)
    );

    pmc_next_mode u_next (
        .cur        (mode_q),
        .evt        (evt),
        .wr_en      (wr_en_i),
        .wr_code    (wr_code_i),
        .timer_done (timer_done),
        .nxt        (mode_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= PM_INIT;
        else
            mode_q <= mode_d;
    end

    assign mode_o     = mode_q;
    assign vreg_en_o  = mode_has_supply(mode_q);
    assign mcu_rst_o  = mode_holds_reset(mode_q);
    assign wdog_run_o = mode_runs_wdog(mode_q) && !dev_mode;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_i,
    input logic [2:0] wr_code_i,
    input logic       wake_i,
    input logic       uv_i,
    input logic       tsd_i,
    input logic       short_i,
    input logic [2:0] mode_o,
    input logic       vreg_en_o,
    input logic       mcu_rst_o,
    input logic       wdog_run_o
);
    // R5
    fs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (tsd_i || short_i) |=> (mode_o == 3'b101 && !vreg_en_o));

    // R6
    fs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'b101 && !wake_i) |=> (mode_o == 3'b101));

    // R7
    uv_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (uv_i && !tsd_i && !short_i && mode_o != 3'b011 && mode_o != 3'b101)
        |=> (mode_o == 3'b100 && mcu_rst_o));

    // R2
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_code_i > 3'b101 && !tsd_i && !short_i && !uv_i && !wake_i
         && mode_o != 3'b100 && mode_o != 3'b011 && mode_o != 3'b101)
        |=> $stable(mode_o));

    // R4
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'b011) |-> (!wdog_run_o && !vreg_en_o && mcu_rst_o));
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_code_i  (wr_code_i),
    .wake_i     (wake_i),
    .uv_i       (uv_i),
    .tsd_i      (tsd_i),
    .short_i    (short_i),
    .mode_o     (mode_o),
    .vreg_en_o  (vreg_en_o),
    .mcu_rst_o  (mcu_rst_o),
    .wdog_run_o (wdog_run_o)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int unsigned RCYC = 16;

    localparam logic [2:0] M_INIT = 3'd0, M_NORM = 3'd1, M_STOP = 3'd2,
                           M_SLP = 3'd3, M_RST = 3'd4, M_FS = 3'd5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_code = 3'd0;
    logic       wake = 1'b0, wdf = 1'b0, uv = 1'b0, tsd = 1'b0, sht = 1'b0;
    logic       test_n = 1'b1;
    logic [2:0] mode;
    logic       vreg_en, mcu_rst, wdog_run;

    int n_cmp = 0;
    int n_bad = 0;
    bit dev_exp = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.RESTART_CYC(RCYC)) u_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_code_i(wr_code),
        .wake_i(wake), .wdog_fail_i(wdf), .uv_i(uv), .tsd_i(tsd),
        .short_i(sht), .test_n_i(test_n), .mode_o(mode),
        .vreg_en_o(vreg_en), .mcu_rst_o(mcu_rst), .wdog_run_o(wdog_run)
    );

    // {wr_en, code[2:0], wake, wdf, uv, tsd, short, expected mode[2:0]}
    localparam int NV = 18;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 3'd0, 5'b00000, M_INIT},  // idle in Init
        {1'b1, 3'd1, 5'b00000, M_NORM},  // R2 write Normal
        {1'b1, 3'd6, 5'b00000, M_NORM},  // R2 illegal code
        {1'b1, 3'd2, 5'b00000, M_STOP},  // R2 write Stop
        {1'b0, 3'd0, 5'b10000, M_STOP},  // R8 wake no effect
        {1'b1, 3'd3, 5'b00000, M_SLP},   // R2 write Sleep
        {1'b1, 3'd1, 5'b00000, M_SLP},   // R3 write ignored
        {1'b0, 3'd0, 5'b00100, M_SLP},   // R7 uv ignored in Sleep
        {1'b0, 3'd0, 5'b10000, M_RST},   // R8 wake from Sleep
        {1'b0, 3'd0, 5'b01000, M_RST},   // R7 wdog fail in Restart
        {1'b0, 3'd0, 5'b00010, M_FS},    // R5 overtemp
        {1'b0, 3'd0, 5'b10010, M_FS},    // R6 wake while hot
        {1'b0, 3'd0, 5'b00000, M_FS},    // R6 hold
        {1'b1, 3'd1, 5'b00000, M_FS},    // R3 write ignored
        {1'b0, 3'd0, 5'b10000, M_RST},   // R6 wake exits
        {1'b0, 3'd0, 5'b01010, M_FS},    // R5 priority over wdog
        {1'b0, 3'd0, 5'b10000, M_RST},   // R6 wake exits
        {1'b0, 3'd0, 5'b10100, M_RST}    // R7 uv holds Restart
    };

    task automatic chk(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [2:0] em);
        logic ev, er, ew;
        ev = !(em == M_SLP || em == M_FS);
        er = (em == M_RST || em == M_SLP || em == M_FS);
        ew = !dev_exp && (em == M_INIT || em == M_NORM || em == M_STOP);
        chk(req, "mode", mode, em);
        chk("R4", "vreg_en", {2'b0, vreg_en}, {2'b0, ev});
        chk("R4", "mcu_rst", {2'b0, mcu_rst}, {2'b0, er});
        chk(req, "wdog_run", {2'b0, wdog_run}, {2'b0, ew});
    endtask

    task automatic drive(input logic we, input logic [2:0] c, input logic [4:0] ev);
        wr_en = we; wr_code = c;
        {wake, wdf, uv, tsd, sht} = ev;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        drive(1'b0, 3'd0, 5'b0);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        step(); step();
        rst = 1'b0;
        chk_all("R1", M_INIT);                       // R1 reset state

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][11], VEC[v][10:8], VEC[v][7:3]);
            step();
            chk_all("R2/R3/R5-R8 vector", VEC[v][2:0]);
        end

        // R9: restart length, count from the uv cycle above
        idle(RCYC - 1);
        chk_all("R9 still restart", M_RST);
        idle(1);
        chk_all("R9 back to Normal", M_NORM);

        // R9: failure mid-delay restarts the count
        drive(1'b0, 3'd0, 5'b01000); step();
        chk_all("R7 wdog from Normal", M_RST);
        idle(10);
        drive(1'b0, 3'd0, 5'b00100); step();
        idle(RCYC - 1);
        chk_all("R9 reload", M_RST);
        idle(1);
        chk_all("R9 exit after reload", M_NORM);

        // R2: soft reset and software restart
        drive(1'b1, 3'd0, 5'b0); step();
        chk_all("R2 write Init", M_INIT);
        drive(1'b1, 3'd7, 5'b0); step();
        chk_all("R2 code 7 ignored", M_INIT);
        drive(1'b1, 3'd4, 5'b0); step();
        chk_all("R2 write Restart", M_RST);
        idle(RCYC);
        chk_all("R9 exit", M_NORM);

        // R5: short from Stop
        drive(1'b1, 3'd2, 5'b0); step();
        drive(1'b0, 3'd0, 5'b00001); step();
        chk_all("R5 short", M_FS);

        // R10: development strap
        rst = 1'b1; test_n = 1'b0; idle(1);
        rst = 1'b0; idle(1);
        dev_exp = 1'b1;
        test_n = 1'b1;
        chk_all("R10 dev in Init", M_INIT);
        drive(1'b1, 3'd1, 5'b0); step();
        chk_all("R10 dev Normal", M_NORM);
        drive(1'b0, 3'd0, 5'b01000); step();
        chk_all("R10 wdog ignored", M_NORM);
        drive(1'b0, 3'd0, 5'b00100); step();
        chk_all("R10 uv still acts", M_RST);
        idle(RCYC);
        chk_all("R10 dev kept after restart", M_NORM);

        // R1: reset clears development mode
        rst = 1'b1; idle(1);
        rst = 1'b0; dev_exp = 1'b0;
        chk_all("R1 reset again", M_INIT);

        summary();
    end
endmodule